// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This unit performs exception entry for a 32-bit RISC core. Each cycle it looks at an eight-bit request vector, indexed by exception number, and picks the lowest-numbered live request. It then emits a one-cycle redirect carrying three things. The first is the handler address. The second is the return address together with the register that should receive it. The third is the new values of the three interrupt-enable status bits (global enable, exception shadow, breakpoint shadow), which the core writes back.

The exception numbers are fixed as follows:

| Number | Exception | Class |
|---|---|---|
| 0 | reset entry | non-debug |
| 1 | breakpoint | debug |
| 2 | instruction bus error | non-debug |
| 3 | watchpoint | debug |
| 4 | data bus error | non-debug |
| 5 | divide by zero | non-debug |
| 6 | external interrupt | non-debug |
| 7 | system call | non-debug |

Bit 6 of the request vector is the interrupt-pending line. The handler address takes bits 31:8 from a base register and puts the exception number times 32 in its low eight bits. The base is chosen as follows:
- Debug exceptions always use the debug base.
- Non-debug exceptions use the debug base when the remap control is set.
- Otherwise they use the normal exception base.

A two-state machine sequences the work:
- `S_IDLE` waits for a request.
- Transition `take`: `S_IDLE` goes to `S_ENTER` on any live request.
- `S_ENTER` is the single cycle in which all outputs are valid and new requests are not accepted.
- Transition `release`: `S_ENTER` always goes back to `S_IDLE`.

Top module: `exc_entry`

## Requirements
- R1: After reset `redirect_o`, `save_we_o` and `status_we_o` are 0.
- R2: The handler address is `{base[31:8], number[2:0], 5'b00000}`, which equals base plus the exception number times 32.
- R3: When several requests are live together, the lowest exception number is taken. The number is reported on `exc_num_o`, using the numbering in the table above.
- R4: For a non-debug exception (0, 2, 4, 5, 6, 7) the saved address goes to the exception-address register (`save_sel_o`=0). `eie_o` becomes `eie_i | gie_i`, `bie_o` equals `bie_i`, and `gie_o` is 0.
- R5: For a debug exception (1 breakpoint, 3 watchpoint) the saved address goes to the breakpoint-address register (`save_sel_o`=1). `bie_o` becomes `bie_i | gie_i`, `eie_o` equals `eie_i`, `gie_o` is 0, and the base is always `deba_i`.
- R6: A non-debug exception vectors from `deba_i` when `remap_i` is 1 and from `eba_i` when it is 0.
- R7: Request bit 6 (interrupt) is taken only when `gie_i` is 1. With `gie_i` at 0 it is ignored: no redirect follows from it, and a lower-priority request is taken instead.
- R8: A request sampled at a clock edge gives `redirect_o`, `save_we_o` and `status_we_o` high for exactly the next cycle, with `save_pc_o` equal to the `cur_pc_i` sampled at that edge.
- R9: Requests present during a redirect cycle are not accepted. A request held continuously therefore redirects every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc_i | input | 32 | PC of the instruction being excepted |
| exc_req_i | input | 8 | Request per exception number; bit 6 is interrupt pending |
| gie_i | input | 1 | Current global interrupt enable |
| eie_i | input | 1 | Current exception shadow enable |
| bie_i | input | 1 | Current breakpoint shadow enable |
| eba_i | input | 24 | Normal exception base, bits 31:8 |
| deba_i | input | 24 | Debug exception base, bits 31:8 |
| remap_i | input | 1 | Move non-debug vectors onto the debug base |
| redirect_o | output | 1 | PC redirect strobe |
| target_pc_o | output | 32 | Handler address |
| exc_num_o | output | 3 | Number of the exception taken |
| save_we_o | output | 1 | Return-address write strobe |
| save_sel_o | output | 1 | 0: exception-address register, 1: breakpoint-address register |
| save_pc_o | output | 32 | Return address to store |
| status_we_o | output | 1 | Status-bit write strobe |
| gie_o | output | 1 | New global enable |
| eie_o | output | 1 | New exception shadow enable |
| bie_o | output | 1 | New breakpoint shadow enable |

## Verification
The hardest situation to reach from the ports is a request that arrives while a redirect is already in progress. It must be dropped, and a fresh request in the following cycle must still be taken. The stimulus reaches this by drawing dense random request vectors every cycle, so back-to-back requests land on the `S_ENTER` cycle often, and it adds a directed held request. A second hard case is an interrupt masked by a low global enable while a lower-priority system call is live. The mixed random bit patterns with `gie_i` toggled produce this case, and a directed cycle covers it as well.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EXC_RESET = 3'd0,
        EXC_BREAK = 3'd1,
        EXC_IBUS  = 3'd2,
        EXC_WATCH = 3'd3,
        EXC_DBUS  = 3'd4,
        EXC_DIVZ  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_SCALL = 3'd7
    } exc_code_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ENTER = 1'b1
    } entry_state_e;

    typedef struct packed {
        logic gie;
        logic eie;
        logic bie;
    } ie_bits_t;

    function automatic logic is_debug(input logic [2:0] num);
        return (num == EXC_BREAK) || (num == EXC_WATCH);
    endfunction

endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int N   = 8,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           any_o,
    output logic [IDW-1:0] idx_o
);
    logic [N:0]   below;
    logic [N-1:0] grant;

    assign below[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            assign below[g+1] = below[g] | req_i[g];
            assign grant[g]   = req_i[g] & ~below[g];
        end
    endgenerate

    assign any_o = below[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx_o = idx_o | IDW'(i);
        end
    end
endmodule

// File: rtl/exc_vec.sv
module exc_vec #(
    parameter int XLEN      = 32,
    parameter int NUM_W     = 3,
    parameter int VEC_SHIFT = 5,
    parameter int BASE_LSB  = NUM_W + VEC_SHIFT
) (
    input  logic [NUM_W-1:0]         num_i,
    input  logic                     debug_i,
    input  logic                     remap_i,
    input  logic [XLEN-1:BASE_LSB]   eba_i,
    input  logic [XLEN-1:BASE_LSB]   deba_i,
    output logic [XLEN-1:0]          vec_o
);
    logic [XLEN-1:BASE_LSB] base;

    always_comb begin
        if (debug_i || remap_i) base = deba_i;
        else                    base = eba_i;
        vec_o = {base, num_i, {VEC_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/exc_stat.sv
module exc_stat
    import exc_pkg::*;
(
    input  logic     debug_i,
    input  ie_bits_t cur_i,
    output ie_bits_t nxt_o
);
    always_comb begin
        nxt_o     = cur_i;
        nxt_o.gie = 1'b0;
        if (debug_i) nxt_o.bie = cur_i.bie | cur_i.gie;
        else         nxt_o.eie = cur_i.eie | cur_i.gie;
    end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NUM_EXC   = 8,
    parameter int VEC_SHIFT = 5,
    parameter int IRQ_BIT   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      cur_pc_i,
    input  logic [NUM_EXC-1:0]   exc_req_i,
    input  logic                 gie_i,
    input  logic                 eie_i,
    input  logic                 bie_i,
    input  logic [XLEN-1:8]      eba_i,
    input  logic [XLEN-1:8]      deba_i,
    input  logic                 remap_i,
    output logic                 redirect_o,
    output logic [XLEN-1:0]      target_pc_o,
    output logic [2:0]           exc_num_o,
    output logic                 save_we_o,
    output logic                 save_sel_o,
    output logic [XLEN-1:0]      save_pc_o,
    output logic                 status_we_o,
    output logic                 gie_o,
    output logic                 eie_o,
    output logic                 bie_o
);
    localparam int NUM_W    = $clog2(NUM_EXC);
    localparam int BASE_LSB = NUM_W + VEC_SHIFT;

    entry_state_e state, state_nxt;

    logic [NUM_EXC-1:0] live;
    logic               any_live;
    logic [NUM_W-1:0]   pick_num;
    logic               pick_dbg;
    logic [XLEN-1:0]    vec;
    ie_bits_t           ie_cur, ie_nxt;
    logic               take;

    // Interrupt line is masked by the global enable; other lines pass through.
    genvar g;
    generate
        for (g = 0; g < NUM_EXC; g++) begin : g_live
            if (g == IRQ_BIT) begin : g_irq
                assign live[g] = exc_req_i[g] & gie_i;
            end else begin : g_plain
                assign live[g] = exc_req_i[g];
            end
        end
    endgenerate

    exc_pick #(.N(NUM_EXC), .IDW(NUM_W)) u_pick (
        .req_i (live),
        .any_o (any_live),
        .idx_o (pick_num)
    );

    assign pick_dbg = is_debug(3'(pick_num));

    exc_vec #(.XLEN(XLEN), .NUM_W(NUM_W), .VEC_SHIFT(VEC_SHIFT), .BASE_LSB(BASE_LSB)) u_vec (
        .num_i   (pick_num),
        .debug_i (pick_dbg),
        .remap_i (remap_i),
        .eba_i   (eba_i),
        .deba_i  (deba_i),
        .vec_o   (vec)
    );

    assign ie_cur = '{gie: gie_i, eie: eie_i, bie: bie_i};

    exc_stat u_stat (
        .debug_i (pick_dbg),
        .cur_i   (ie_cur),
        .nxt_o   (ie_nxt)
    );

    assign take = (state == S_IDLE) && any_live;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (any_live) state_nxt = S_ENTER;  // take
            S_ENTER: state_nxt = S_IDLE;                 // release
            default: state_nxt = S_IDLE;
        endcase
    end

    // Outputs: loaded on take, strobes live for the S_ENTER cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_o  <= 1'b0;
            save_we_o   <= 1'b0;
            status_we_o <= 1'b0;
            target_pc_o <= '0;
            exc_num_o   <= '0;
            save_sel_o  <= 1'b0;
            save_pc_o   <= '0;
            gie_o       <= 1'b0;
            eie_o       <= 1'b0;
            bie_o       <= 1'b0;
        end else begin
            redirect_o  <= take;
            save_we_o   <= take;
            status_we_o <= take;
            if (take) begin
                target_pc_o <= vec;
                exc_num_o   <= 3'(pick_num);
                save_sel_o  <= pick_dbg;
                save_pc_o   <= cur_pc_i;
                gie_o       <= ie_nxt.gie;
                eie_o       <= ie_nxt.eie;
                bie_o       <= ie_nxt.bie;
            end
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN    = 32,
    parameter int NUM_EXC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [XLEN-1:0]    cur_pc_i,
    input logic [NUM_EXC-1:0] exc_req_i,
    input logic               gie_i,
    input logic [XLEN-1:8]    deba_i,
    input logic               redirect_o,
    input logic [XLEN-1:0]    target_pc_o,
    input logic [2:0]         exc_num_o,
    input logic               save_we_o,
    input logic               save_sel_o,
    input logic [XLEN-1:0]    save_pc_o,
    input logic               status_we_o,
    input logic               gie_o
);
    // R9
    single_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // R8
    strobes_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (save_we_o && status_we_o));

    // R8
    save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (save_pc_o == $past(cur_pc_i)));

    // R4
    gie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !gie_o);

    // R5
    debug_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && save_sel_o) |-> (target_pc_o[XLEN-1:8] == $past(deba_i)));

    // R7
    irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && exc_num_o == 3'd6) |-> $past(gie_i));

    // R3
    taken_was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (($past(exc_req_i) >> exc_num_o) & 1) != 0);

    // R2
    vec_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (target_pc_o[7:0] == {exc_num_o, 5'b00000}));
endmodule

bind exc_entry exc_entry_chk #(.XLEN(XLEN), .NUM_EXC(NUM_EXC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_pc_i    (cur_pc_i),
    .exc_req_i   (exc_req_i),
    .gie_i       (gie_i),
    .deba_i      (deba_i),
    .redirect_o  (redirect_o),
    .target_pc_o (target_pc_o),
    .exc_num_o   (exc_num_o),
    .save_we_o   (save_we_o),
    .save_sel_o  (save_sel_o),
    .save_pc_o   (save_pc_o),
    .status_we_o (status_we_o),
    .gie_o       (gie_o)
);

// File: tb/sim_exc_entry.sv
`timescale 1ns/1ps
module sim_exc_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc_i = '0;
    logic [7:0]  exc_req_i = '0;
    logic        gie_i = 1'b0, eie_i = 1'b0, bie_i = 1'b0, remap_i = 1'b0;
    logic [31:8] eba_i = '0, deba_i = '0;
    logic        redirect_o, save_we_o, save_sel_o, status_we_o;
    logic        gie_o, eie_o, bie_o;
    logic [31:0] target_pc_o, save_pc_o;
    logic [2:0]  exc_num_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exc_entry u0 (.*);

    // expected next-cycle outputs
    logic        e_red;
    logic [31:0] e_tgt, e_spc;
    logic [2:0]  e_num;
    logic        e_sel, e_gie, e_eie, e_bie;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pick(input logic [7:0] req, input logic gie);
        logic [7:0] l;
        l = req;
        if (!gie) l[6] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (l[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    task automatic predict();
        logic [3:0] p;
        logic       dbg;
        p = pick(exc_req_i, gie_i);
        if (e_red || !p[3]) begin
            e_red = 1'b0;   // R9: ignored while in redirect
        end else begin
            e_red = 1'b1;
            e_num = p[2:0];
            dbg   = (p[2:0] == 3'd1) || (p[2:0] == 3'd3);
            e_sel = dbg;
            e_spc = cur_pc_i;
            e_tgt = {((dbg || remap_i) ? deba_i : eba_i), p[2:0], 5'b0};
            e_gie = 1'b0;
            e_eie = dbg ? eie_i : (eie_i | gie_i);
            e_bie = dbg ? (bie_i | gie_i) : bie_i;
        end
    endtask

    task automatic compare();
        chk("R8 redirect", {31'b0, redirect_o}, {31'b0, e_red});
        chk("R8 save_we", {31'b0, save_we_o}, {31'b0, e_red});
        chk("R8 status_we", {31'b0, status_we_o}, {31'b0, e_red});
        if (e_red) begin
            chk("R3 exc_num", {29'b0, exc_num_o}, {29'b0, e_num});
            chk(e_sel ? "R5 target" : "R2/R6 target", target_pc_o, e_tgt);
            chk(e_sel ? "R5 save_sel" : "R4 save_sel", {31'b0, save_sel_o}, {31'b0, e_sel});
            chk("R8 save_pc", save_pc_o, e_spc);
            chk(e_sel ? "R5 status" : "R4 status", {29'b0, gie_o, eie_o, bie_o},
                {29'b0, e_gie, e_eie, e_bie});
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2468));
        e_red = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 redirect", {31'b0, redirect_o}, 32'd0);
        chk("R1 save_we", {31'b0, save_we_o}, 32'd0);
        chk("R1 status_we", {31'b0, status_we_o}, 32'd0);
        eba_i  = 24'h00_1200;
        deba_i = 24'hAB_CD00;
        for (int i = 0; i < 4000; i++) begin
            if (i > 0) begin
                @(negedge clk);
                compare();
            end
            cur_pc_i = $urandom & 32'hFFFF_FFFC;
            case (i)
                0: begin exc_req_i = 8'h00; gie_i = 1; end
                1: begin exc_req_i = 8'h80; gie_i = 1; eie_i = 0; remap_i = 0; end // R4
                2: begin exc_req_i = 8'h80; end                                   // R9 held
                3: begin exc_req_i = 8'h80; end                                   // R9 taken again
                4: begin exc_req_i = 8'h00; end
                5: begin exc_req_i = 8'hC0; gie_i = 0; end                        // R7 masked irq
                6: begin exc_req_i = 8'h00; end
                7: begin exc_req_i = 8'h48; gie_i = 1; bie_i = 0; end             // R5 watchpoint
                8: begin exc_req_i = 8'h00; end
                9: begin exc_req_i = 8'hFF; end                                   // R3 reset wins
                10: begin exc_req_i = 8'h00; end
                11: begin exc_req_i = 8'h20; remap_i = 1; end                     // R6 remap
                12: begin exc_req_i = 8'h00; end
                13: begin exc_req_i = 8'h40; gie_i = 0; end                       // R7 ignored
                default: begin
                    for (int b = 0; b < 8; b++) exc_req_i[b] = (($urandom % 5) == 0);
                    gie_i   = $urandom % 2;
                    eie_i   = $urandom % 2;
                    bie_i   = $urandom % 2;
                    remap_i = $urandom % 2;
                    if (($urandom % 8) == 0) begin
                        eba_i  = $urandom;
                        deba_i = $urandom;
                    end
                end
            endcase
            predict();
        end
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule